// File: doc/BRIEF.md
# Three-Input Hash and Cipher Execution Datapath

This block is the execution core of a small processor built for hash and cipher rounds. Each instruction word feeds two first-stage units that run side by side. Each of these units reads two registers and folds in a 32-bit constant taken from the instruction, using a single opcode for both steps. A closing unit then merges the two partial results under a third opcode. Only that merged value is written back, into one destination register. The datapath has no branches and no caches, and its timing never depends on data. Every instruction takes the same number of cycles and at most one register is written per clock.

The pipeline has three stages. The first decodes the word and reads four source registers from a sixteen-entry file. The second evaluates the two first-stage units. The third combines their results and writes the register file. The write-back value is passed straight to the operand read of the instruction issued in the same cycle. An instruction therefore sees the result of every instruction issued two or more cycles before it. It does not see the result of the instruction issued in the cycle just before it. Software schedules around that single slot.

Top module: `tern_datapath`

## Requirements
- R1: Reset clears every register to zero, and no write-back is reported in the first two cycles after reset is released.
- R2: A first-stage unit with opcode p, register operands x and y and constant k yields (x p y) p k. The opcodes are 0 add (modulo 2^32), 1 xor, 2 and, 3 or, 4 and-not (left & ~right), 5 rotate left, 6 shift left and 7 logical shift right.
- R3: The closing unit yields A q B, where A is the result of unit A, B is the result of unit B and q is the third opcode. It uses the same opcode table.
- R4: An instruction accepted in cycle k shows its result on the write-back port in cycle k+2 with its destination index. Exactly one write is reported per accepted instruction.
- R5: For rotate and shift opcodes, the right operand gives the amount modulo 32, so an amount of 35 acts as 3.
- R6: And-not clears in the left operand the bits that are set in the right operand.
- R7: An opcode value from 8 to 31 returns its left operand unchanged.
- R8: An instruction reads the value written by an instruction issued two or more cycles earlier. It reads the old value for a write by the instruction issued one cycle earlier.
- R9: Instruction bits 143:99 have no effect on any result. The field positions are: unit A constant 31:0, unit B constant 63:32, destination 67:64, unit A sources 71:68 and 75:72, unit B sources 79:76 and 83:80, unit A opcode 88:84, unit B opcode 93:89, closing opcode 98:94.
- R10: A word presented while instr_valid is low produces no write-back and leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 144 | Instruction word |
| wb_valid | output | 1 | A register is written at the end of this cycle |
| wb_dst | output | 4 | Destination register index of the write |
| wb_data | output | 32 | Value written |

## Verification
The assertions assume that instr_valid is held low while reset is asserted. They also assume that the instruction word carries no unknown bits whenever instr_valid is high, because the write-back timing and destination are tracked back through the word presented two cycles earlier. The stimulus holds valid low through reset and drives fully defined words on every cycle, including idle cycles with random contents. A reference model in the bench applies each write at the moment the single delay slot allows. It also compares the write-back port on every cycle, so back-to-back reads of a freshly written register are checked.

// File: rtl/tern_pkg.sv
package tern_pkg;

    parameter int unsigned DATA_W = 32;
    parameter int unsigned IDX_W  = 4;
    parameter int unsigned OP_W   = 5;
    parameter int unsigned NSRC   = 4;
    parameter int unsigned NREG   = 16;

    // Field positions inside the instruction word, lowest first.
    localparam int unsigned IMM_LO  = 0;
    localparam int unsigned DST_LO  = IMM_LO + 2 * DATA_W;
    localparam int unsigned SRC_LO  = DST_LO + IDX_W;
    localparam int unsigned OPA_LO  = SRC_LO + NSRC * IDX_W;
    localparam int unsigned OPB_LO  = OPA_LO + OP_W;
    localparam int unsigned OPC_LO  = OPB_LO + OP_W;
    localparam int unsigned USED_W  = OPC_LO + OP_W;
    localparam int unsigned SHAMT_W = $clog2(DATA_W);

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_XOR  = 5'd1,
        OP_AND  = 5'd2,
        OP_OR   = 5'd3,
        OP_ANDN = 5'd4,
        OP_ROTL = 5'd5,
        OP_SHL  = 5'd6,
        OP_SHR  = 5'd7
    } op_e;

    typedef struct packed {
        logic [OP_W-1:0]             op_c;
        logic [1:0][OP_W-1:0]        op_ab;
        logic [NSRC-1:0][IDX_W-1:0]  src;
        logic [IDX_W-1:0]            dst;
        logic [1:0][DATA_W-1:0]      imm;
    } instr_t;

    // Two-operand primitive shared by every unit.
    function automatic logic [DATA_W-1:0] op_apply(
        input logic [OP_W-1:0]   op,
        input logic [DATA_W-1:0] lhs,
        input logic [DATA_W-1:0] rhs
    );
        logic [SHAMT_W-1:0]  amt;
        logic [2*DATA_W-1:0] dbl;
        logic [DATA_W-1:0]   res;
        amt = rhs[SHAMT_W-1:0];
        dbl = {lhs, lhs} << amt;
        case (op)
            OP_ADD:  res = lhs + rhs;
            OP_XOR:  res = lhs ^ rhs;
            OP_AND:  res = lhs & rhs;
            OP_OR:   res = lhs | rhs;
            OP_ANDN: res = lhs & ~rhs;
            OP_ROTL: res = dbl[2*DATA_W-1:DATA_W];
            OP_SHL:  res = lhs << amt;
            OP_SHR:  res = lhs >> amt;
            default: res = lhs;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/tern_decode.sv
module tern_decode
    import tern_pkg::*;
#(
    parameter int unsigned INSTR_W = 144
) (
    input  logic [INSTR_W-1:0] raw,
    output instr_t             fields
);

    always_comb begin
        fields       = '0;
        fields.imm[0] = raw[IMM_LO +: DATA_W];
        fields.imm[1] = raw[IMM_LO + DATA_W +: DATA_W];
        fields.dst    = raw[DST_LO +: IDX_W];
        for (int s = 0; s < NSRC; s++) begin
            fields.src[s] = raw[SRC_LO + s * IDX_W +: IDX_W];
        end
        fields.op_ab[0] = raw[OPA_LO +: OP_W];
        fields.op_ab[1] = raw[OPB_LO +: OP_W];
        fields.op_c     = raw[OPC_LO +: OP_W];
    end

    generate
        if (INSTR_W > USED_W) begin : g_pad
            logic unused_pad;
            assign unused_pad = ^raw[INSTR_W-1:USED_W];
        end
    endgenerate

endmodule

// File: rtl/tern_regfile.sv
module tern_regfile #(
    parameter int unsigned NREG   = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned NRD    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NRD-1:0][IDX_W-1:0]    rd_idx,
    output logic [NRD-1:0][DATA_W-1:0]   rd_data,
    input  logic                         we,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data
);

    logic [NREG-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    // Write-through: a read of the register being written sees the new value.
    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            assign rd_data[p] = (we && (wr_idx == rd_idx[p])) ? wr_data : mem_q[rd_idx[p]];
        end
    endgenerate

endmodule

// File: rtl/tern_unit.sv
module tern_unit
    import tern_pkg::*;
#(
    parameter bit USE_IMM = 1'b1
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] c,
    output logic [DATA_W-1:0] y
);

    generate
        if (USE_IMM) begin : g_three
            logic [DATA_W-1:0] inner;
            assign inner = op_apply(op, a, b);
            assign y     = op_apply(op, inner, c);
        end else begin : g_two
            logic unused_c;
            assign unused_c = ^c;
            assign y        = op_apply(op, a, b);
        end
    endgenerate

endmodule

// File: rtl/tern_datapath.sv
module tern_datapath
    import tern_pkg::*;
#(
    parameter int unsigned INSTR_W = 144
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [INSTR_W-1:0]   instr,
    output logic                 wb_valid,
    output logic [IDX_W-1:0]     wb_dst,
    output logic [DATA_W-1:0]    wb_data
);

    localparam int unsigned NUNIT = 2;

    typedef struct packed {
        logic                           v;
        logic [NSRC-1:0][DATA_W-1:0]    opnd;
        logic [NUNIT-1:0][DATA_W-1:0]   imm;
        logic [NUNIT-1:0][OP_W-1:0]     op_ab;
        logic [OP_W-1:0]                op_c;
        logic [IDX_W-1:0]               dst;
    } read_stage_t;

    typedef struct packed {
        logic                           v;
        logic [NUNIT-1:0][DATA_W-1:0]   part;
        logic [OP_W-1:0]                op_c;
        logic [IDX_W-1:0]               dst;
    } exec_stage_t;

    typedef struct packed {
        read_stage_t rd;
        exec_stage_t ex;
    } pipe_t;

    pipe_t state_d, state_q;

    instr_t                        dec;
    logic [NSRC-1:0][DATA_W-1:0]   rf_rd;
    logic [NUNIT-1:0][DATA_W-1:0]  part_y;
    logic [DATA_W-1:0]             merge_y;

    tern_decode #(.INSTR_W(INSTR_W)) u_decode (
        .raw    (instr),
        .fields (dec)
    );

    tern_regfile #(
        .NREG   (NREG),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .NRD    (NSRC)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (dec.src),
        .rd_data (rf_rd),
        .we      (state_q.ex.v),
        .wr_idx  (state_q.ex.dst),
        .wr_data (merge_y)
    );

    generate
        for (genvar u = 0; u < NUNIT; u++) begin : g_first
            tern_unit #(.USE_IMM(1'b1)) u_first (
                .op (state_q.rd.op_ab[u]),
                .a  (state_q.rd.opnd[2*u]),
                .b  (state_q.rd.opnd[2*u+1]),
                .c  (state_q.rd.imm[u]),
                .y  (part_y[u])
            );
        end
    endgenerate

    tern_unit #(.USE_IMM(1'b0)) u_merge (
        .op (state_q.ex.op_c),
        .a  (state_q.ex.part[0]),
        .b  (state_q.ex.part[1]),
        .c  ('0),
        .y  (merge_y)
    );

    always_comb begin
        state_d = state_q;

        state_d.rd.v     = instr_valid;
        state_d.rd.opnd  = rf_rd;
        state_d.rd.imm   = dec.imm;
        state_d.rd.op_ab = dec.op_ab;
        state_d.rd.op_c  = dec.op_c;
        state_d.rd.dst   = dec.dst;

        state_d.ex.v     = state_q.rd.v;
        state_d.ex.part  = part_y;
        state_d.ex.op_c  = state_q.rd.op_c;
        state_d.ex.dst   = state_q.rd.dst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign wb_valid = state_q.ex.v;
    assign wb_dst   = state_q.ex.dst;
    assign wb_data  = merge_y;

endmodule

// File: rtl/tern_checker.sv
module tern_checker
    import tern_pkg::*;
#(
    parameter int unsigned INSTR_W = 144
) (
    input logic                clk,
    input logic                rst_n,
    input logic                instr_valid,
    input logic [INSTR_W-1:0]  instr,
    input logic                wb_valid,
    input logic [IDX_W-1:0]    wb_dst,
    input logic [DATA_W-1:0]   wb_data
);

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    AST_NO_EARLY_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd2) |-> !wb_valid); // R1

    AST_WB_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && $past(instr_valid, 2)) |-> wb_valid); // R4

    AST_WB_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && wb_valid) |-> (wb_dst == $past(instr[DST_LO +: IDX_W], 2))); // R4

    AST_IDLE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && !$past(instr_valid, 2)) |-> !wb_valid); // R10

    AST_WB_DATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !$isunknown(wb_data)); // R3

endmodule

bind tern_datapath tern_checker #(.INSTR_W(INSTR_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .wb_valid    (wb_valid),
    .wb_dst      (wb_dst),
    .wb_data     (wb_data)
);

// File: tb/tb_tern_datapath.sv
module tb_tern_datapath;

    localparam int IW = 144;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [IW-1:0] instr = '0;
    logic          wb_valid;
    logic [3:0]    wb_dst;
    logic [31:0]   wb_data;

    tern_datapath dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr       (instr),
        .wb_valid    (wb_valid),
        .wb_dst      (wb_dst),
        .wb_data     (wb_data)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          v;
        logic [3:0]  dst;
        logic [31:0] data;
        string       tag;
    } exp_t;

    logic [31:0] model_reg [16];
    exp_t        pending [$];

    function automatic logic [31:0] ref_op(int op, logic [31:0] x, logic [31:0] y);
        int          sh;
        logic [63:0] wide;
        sh = int'(y % 32);
        case (op)
            0: return x + y;
            1: return x ^ y;
            2: return x & y;
            3: return x | y;
            4: return x & ~y;
            5: begin
                wide = {32'd0, x} << sh;
                return wide[31:0] | wide[63:32];
            end
            6: return x << sh;
            7: return x >> sh;
            default: return x;
        endcase
    endfunction

    function automatic logic [IW-1:0] mk(int oa, int ob, int oc,
                                         int sa0, int sa1, int sb0, int sb1, int d,
                                         logic [31:0] ka, logic [31:0] kb, logic [44:0] pad);
        logic [IW-1:0] w;
        w = '0;
        w[31:0]    = ka;
        w[63:32]   = kb;
        w[67:64]   = d[3:0];
        w[71:68]   = sa0[3:0];
        w[75:72]   = sa1[3:0];
        w[79:76]   = sb0[3:0];
        w[83:80]   = sb1[3:0];
        w[88:84]   = oa[4:0];
        w[93:89]   = ob[4:0];
        w[98:94]   = oc[4:0];
        w[143:99]  = pad;
        return w;
    endfunction

    task automatic fail(string tag, string what, logic [31:0] act, logic [31:0] expv);
        errors++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    endtask

    // One clock cycle: check the write-back due now, then present a new word.
    task automatic issue(bit v, logic [IW-1:0] w, string tag);
        exp_t        e;
        exp_t        n;
        logic [31:0] ra, rb;
        @(negedge clk);
        e = pending.pop_front();
        checks++;
        if (wb_valid !== e.v) fail(e.tag, "wb_valid", 32'(wb_valid), 32'(e.v));
        if (e.v) begin
            checks++;
            if (wb_dst !== e.dst) fail(e.tag, "wb_dst", 32'(wb_dst), 32'(e.dst));
            else if (wb_data !== e.data) fail(e.tag, "wb_data", wb_data, e.data);
            model_reg[e.dst] = e.data;
        end
        ra = ref_op(int'(w[88:84]), ref_op(int'(w[88:84]), model_reg[w[71:68]], model_reg[w[75:72]]), w[31:0]);
        rb = ref_op(int'(w[93:89]), ref_op(int'(w[93:89]), model_reg[w[79:76]], model_reg[w[83:80]]), w[63:32]);
        n.v    = v;
        n.dst  = w[67:64];
        n.data = ref_op(int'(w[98:94]), ra, rb);
        n.tag  = tag;
        pending.push_back(n);
        instr_valid = v;
        instr       = w;
    endtask

    task automatic load(int d, logic [31:0] val, string tag);
        issue(1'b1, mk(1, 1, 1, 0, 0, 0, 0, d, 32'd0, val, 45'd0), tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        exp_t idle;
        logic [IW-1:0] w;
        for (int i = 0; i < 16; i++) model_reg[i] = 32'd0;
        idle.v = 1'b0; idle.dst = 4'd0; idle.data = 32'd0; idle.tag = "R1";

        // R1: quiet during reset
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (wb_valid !== 1'b0) fail("R1", "wb_valid in reset", 32'(wb_valid), 32'd0);
        end
        rst_n = 1'b1;
        pending.push_back(idle);
        pending.push_back(idle);

        // R1: registers read zero after reset
        issue(1'b1, mk(3, 0, 3, 3, 4, 7, 9, 1, 32'd0, 32'd0, 45'd0), "R1");
        issue(1'b0, '0, "R1");

        load(1, 32'h8000_0001, "R2");
        load(2, 32'd35, "R2");
        load(3, 32'hF0F0_F0F0, "R2");
        load(4, 32'h0FF0_0FF0, "R2");
        load(6, 32'd3, "R2");
        issue(1'b0, '0, "R2");

        // R2: add with wrap, xor
        issue(1'b1, mk(0, 1, 0, 1, 1, 3, 4, 7, 32'hFFFF_FFFF, 32'h1234_5678, 45'd0), "R2");
        // R6: and-not in both units, combined by and
        issue(1'b1, mk(4, 4, 2, 3, 4, 4, 3, 8, 32'h0000_00F0, 32'h0F00_0000, 45'd0), "R6");
        // R5: rotate by 35 then constant 33, shift left / right
        issue(1'b1, mk(5, 6, 1, 1, 2, 3, 2, 9, 32'd33, 32'd1, 45'd0), "R5");
        issue(1'b1, mk(7, 5, 3, 3, 6, 1, 6, 10, 32'd36, 32'd64, 45'd0), "R5");
        // R3: every closing opcode on the same pair
        for (int q = 0; q < 8; q++)
            issue(1'b1, mk(0, 1, q, 1, 3, 4, 6, 11, 32'h0000_0013, 32'h0000_0005, 45'd0), "R3");
        // R7: undefined opcodes return left operand
        issue(1'b1, mk(20, 1, 31, 3, 4, 1, 6, 12, 32'h5555_AAAA, 32'd0, 45'd0), "R7");
        issue(1'b1, mk(8, 17, 9, 4, 3, 6, 1, 13, 32'hDEAD_BEEF, 32'h1, 45'd0), "R7");

        // R8: one delay slot
        load(5, 32'hCAFE_0001, "R8");
        issue(1'b1, mk(3, 2, 1, 5, 5, 0, 0, 14, 32'd0, 32'd0, 45'd0), "R8");
        issue(1'b1, mk(3, 2, 1, 5, 5, 0, 0, 15, 32'd0, 32'd0, 45'd0), "R8");
        issue(1'b0, '0, "R8");

        // R9: padding bits ignored
        w = mk(0, 5, 1, 3, 4, 1, 2, 7, 32'h0101_0101, 32'd7, 45'd0);
        issue(1'b1, w, "R9");
        w[143:99] = 45'h1F_FFFF_FFFF_FF;
        issue(1'b1, w, "R9");
        w[143:99] = 45'h0A_5A5A_5A5A_5A;
        issue(1'b1, w, "R9");

        // R10: invalid words do not write; read back the targeted register
        issue(1'b0, mk(1, 1, 1, 0, 0, 0, 0, 3, 32'hFFFF_FFFF, 32'h1111_1111, 45'd0), "R10");
        issue(1'b0, mk(0, 0, 0, 1, 1, 1, 1, 3, 32'h1, 32'h2, 45'h3), "R10");
        issue(1'b1, mk(3, 2, 3, 3, 3, 0, 0, 0, 32'd0, 32'd0, 45'd0), "R10");
        issue(1'b0, '0, "R10");
        issue(1'b0, '0, "R10");

        // R4/R2/R3: random traffic, occasional idle cycles
        for (int i = 0; i < 500; i++) begin
            logic [IW-1:0] rw;
            bit            rv;
            rw = {$urandom, $urandom, $urandom, $urandom, $urandom};
            rv = ($urandom % 5) != 0;
            rw[88:84] = 5'($urandom % 9);
            rw[93:89] = 5'($urandom % 9);
            rw[98:94] = 5'($urandom % 9);
            issue(rv, rw, "R4");
        end

        repeat (3) issue(1'b0, '0, "R4");
        finish_run();
    end

endmodule